// File: doc/BRIEF.md
# Selectable-Clock Base Timer

This block is a free-running 14-bit binary counter used for timekeeping. On each clock cycle it advances by at most one, on a tick from one of three sources chosen by a select field. The sources are an enable pulse from the 32.768 kHz crystal domain (already synchronized to the system clock), a system-clock tick, and the prescaler output of a neighbouring timer. When the crystal tick is used, a carry out of the top bit occurs every 16384 counts, which is 500 ms. A second, shorter period is taken from one of four intermediate bits of the same chain: 32, 128, 512 or 2048 counts, which is roughly 0.98 ms, 3.9 ms, 15.6 ms or 62.5 ms.

Each carry sets a sticky flag. The flags stay set until a clear strobe arrives. An interrupt request is raised while either flag is set and its enable is high. Elsewhere this request shares one vector with an external interrupt line. Changing the source select restarts the counter from zero, so the first period after a switch is always a whole one.

Top module: `base_timer`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, long_flag, short_flag and irq are 0, and the counter is 0.
- R2: src_sel picks the count source: 0 = xtal_tick, 1 = sys_tick, 2 = pre_tick, 3 = no source (the counter holds). Ticks on the sources that are not selected have no effect.
- R3: On each rising clk edge where the selected tick is 1 and no restart is pending, the 14-bit counter advances by one and wraps from 16383 to 0.
- R4: long_flag becomes 1 in the cycle after the edge at which the counter goes from 16383 to 0.
- R5: short_flag becomes 1 in the cycle after the edge at which the count reaches a multiple of the period chosen by ivl_sel: 0 = 32, 1 = 128, 2 = 512, 3 = 2048 counts. These are the carries out of bits 4, 6, 8 and 10.
- R6: Both flags hold until a one-cycle flag_clr pulse clears them both. If a carry arrives in the same cycle as flag_clr, that flag ends up set.
- R7: irq = (long_flag AND long_ie) OR (short_flag AND short_ie), with no added delay.
- R8: On an edge where src_sel differs from its value at the previous edge, the counter is forced to 0 and that edge's tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | Synchronized 32.768 kHz crystal enable pulse |
| sys_tick | input | 1 | System-clock count enable |
| pre_tick | input | 1 | Prescaler output pulse of the neighbouring timer |
| src_sel | input | 2 | Count source select (see R2) |
| ivl_sel | input | IVL_W (2) | Short period select (see R5) |
| flag_clr | input | 1 | Clears both flags |
| long_ie | input | 1 | Interrupt enable for long_flag |
| short_ie | input | 1 | Interrupt enable for short_flag |
| long_flag | output | 1 | Sticky flag for the 16384-count carry |
| short_flag | output | 1 | Sticky flag for the selected-tap carry |
| irq | output | 1 | Gated OR of the flags |

## Verification
The assertions check properties that hold on every cycle:
- the counter steps by exactly one or holds, depending on the qualified tick;
- a source change zeroes the counter;
- each carry sets its flag on the next cycle;
- a flag stays set until a clear, and a clear with no carry empties it;
- irq is never high while both flags are low.

Other behaviours need a long run of ticks and are shown only by the bench scenarios against its behavioural model. These are the exact period lengths for each tap and the 16384-count long period. They also include ticks on unselected sources being ignored, and a switch that would let a stale count fire early. The last is set-over-clear priority in a single cycle.

// File: rtl/bt_pkg.sv
package bt_pkg;

   typedef enum logic [1:0] {
      SRC_XTAL = 2'd0,
      SRC_SYS  = 2'd1,
      SRC_PRE  = 2'd2,
      SRC_NONE = 2'd3
   } bt_src_e;

   // Highest bit index whose carry closes a short period for tap i
   function automatic int tap_top_bit(input int lo, input int step, input int i);
      return lo + step * i;
   endfunction

endpackage

// File: rtl/bt_src_mux.sv
module bt_src_mux
   import bt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] src_sel,
   input  logic       xtal_tick,
   input  logic       sys_tick,
   input  logic       pre_tick,
   output logic       cnt_en,
   output logic       restart
);

   bt_src_e src_now;
   bt_src_e src_q;

   assign src_now = bt_src_e'(src_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= SRC_XTAL;
      else        src_q <= src_now;
   end

   assign restart = (src_now != src_q);

   always_comb begin
      unique case (src_now)
         SRC_XTAL: cnt_en = xtal_tick;
         SRC_SYS:  cnt_en = sys_tick;
         SRC_PRE:  cnt_en = pre_tick;
         default:  cnt_en = 1'b0;
      endcase
   end

   AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel == 2'd3) |-> !cnt_en);  // R2

endmodule

// File: rtl/bt_chain.sv
module bt_chain
   import bt_pkg::*;
#(
   parameter int CNT_W    = 14,
   parameter int TAP_LO   = 4,
   parameter int TAP_STEP = 2,
   parameter int N_TAPS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              restart,
   output logic [N_TAPS-1:0] tap_carry,
   output logic              full_carry
);

   localparam int TOP_TAP = TAP_LO + TAP_STEP * (N_TAPS - 1);

   if (TOP_TAP >= CNT_W - 1) begin : g_bad_taps
      $error("bt_chain: highest tap must lie below the top counter bit");
   end
   if (TAP_STEP < 1 || TAP_LO < 0) begin : g_bad_step
      $error("bt_chain: tap spacing must be positive");
   end

   logic [CNT_W-1:0] cnt;
   logic             adv;

   assign adv = cnt_en & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (adv)     cnt <= cnt + 1'b1;
   end

   for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
      localparam int HI = tap_top_bit(TAP_LO, TAP_STEP, i);
      assign tap_carry[i] = adv & (&cnt[HI:0]);
   end

   assign full_carry = adv & (&cnt);

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !restart) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));  // R3
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !restart) |=> $stable(cnt));  // R2
   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));  // R8

endmodule

// File: rtl/bt_flags.sv
module bt_flags #(
   parameter int N_TAPS = 4,
   parameter int IVL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_TAPS-1:0] tap_carry,
   input  logic              full_carry,
   input  logic [IVL_W-1:0]  ivl_sel,
   input  logic              flag_clr,
   output logic              long_flag,
   output logic              short_flag
);

   logic short_ev;

   assign short_ev = (int'(ivl_sel) < N_TAPS) ? tap_carry[ivl_sel] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         long_flag  <= 1'b0;
         short_flag <= 1'b0;
      end else begin
         long_flag  <= (long_flag  & ~flag_clr) | full_carry;
         short_flag <= (short_flag & ~flag_clr) | short_ev;
      end
   end

   AST_LONG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      full_carry |=> long_flag);  // R4
   AST_SHORT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      short_ev |=> short_flag);  // R5
   AST_LONG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (long_flag && !flag_clr) |=> long_flag);  // R6
   AST_SHORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !short_ev) |=> !short_flag);  // R6

endmodule

// File: rtl/base_timer.sv
module base_timer #(
   parameter int CNT_W    = 14,
   parameter int TAP_LO   = 4,
   parameter int TAP_STEP = 2,
   parameter int N_TAPS   = 4,
   parameter int IVL_W    = $clog2(N_TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xtal_tick,
   input  logic             sys_tick,
   input  logic             pre_tick,
   input  logic [1:0]       src_sel,
   input  logic [IVL_W-1:0] ivl_sel,
   input  logic             flag_clr,
   input  logic             long_ie,
   input  logic             short_ie,
   output logic             long_flag,
   output logic             short_flag,
   output logic             irq
);

   if ((1 << IVL_W) < N_TAPS) begin : g_bad_ivl
      $error("base_timer: interval select too narrow for tap count");
   end

   logic              cnt_en;
   logic              restart;
   logic [N_TAPS-1:0] tap_carry;
   logic              full_carry;

   bt_src_mux u_src (
      .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
      .xtal_tick(xtal_tick), .sys_tick(sys_tick), .pre_tick(pre_tick),
      .cnt_en(cnt_en), .restart(restart)
   );

   bt_chain #(.CNT_W(CNT_W), .TAP_LO(TAP_LO), .TAP_STEP(TAP_STEP), .N_TAPS(N_TAPS)) u_chain (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .restart(restart),
      .tap_carry(tap_carry), .full_carry(full_carry)
   );

   bt_flags #(.N_TAPS(N_TAPS), .IVL_W(IVL_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .tap_carry(tap_carry), .full_carry(full_carry),
      .ivl_sel(ivl_sel), .flag_clr(flag_clr),
      .long_flag(long_flag), .short_flag(short_flag)
   );

   assign irq = (long_flag & long_ie) | (short_flag & short_ie);

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (long_flag || short_flag));  // R7
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!long_flag && !short_flag));  // R1

endmodule

// File: tb/sim_base_timer.sv
`timescale 1ns/1ps
module sim_base_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xtal_tick = 1'b0, sys_tick = 1'b0, pre_tick = 1'b0;
   logic [1:0] src_sel = 2'd0;
   logic [1:0] ivl_sel = 2'd0;
   logic       flag_clr = 1'b0;
   logic       long_ie = 1'b1, short_ie = 1'b1;
   logic       long_flag, short_flag, irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   base_timer u0 (
      .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .sys_tick(sys_tick),
      .pre_tick(pre_tick), .src_sel(src_sel), .ivl_sel(ivl_sel),
      .flag_clr(flag_clr), .long_ie(long_ie), .short_ie(short_ie),
      .long_flag(long_flag), .short_flag(short_flag), .irq(irq)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: integer count of qualified ticks
   int   m_cnt = 0;
   bit   m_long = 0, m_short = 0;
   logic [1:0] m_prev = 2'd0;

   always @(posedge clk) begin
      bit t, ev_l, ev_s;
      int per;
      if (!rst_n) begin
         m_cnt = 0; m_long = 0; m_short = 0; m_prev = 2'd0;
      end else begin
         t = (src_sel == 2'd0) ? xtal_tick : (src_sel == 2'd1) ? sys_tick :
             (src_sel == 2'd2) ? pre_tick : 1'b0;
         per = 32 << (2 * ivl_sel);
         ev_l = 0; ev_s = 0;
         if (src_sel != m_prev) m_cnt = 0;
         else if (t) begin
            m_cnt = (m_cnt + 1) % 16384;
            ev_l = (m_cnt == 0);
            ev_s = (m_cnt % per == 0);
         end
         m_prev = src_sel;
         if (flag_clr) begin m_long = 0; m_short = 0; end
         if (ev_l) m_long = 1;
         if (ev_s) m_short = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R4 long_flag vs model", long_flag, m_long);
         chk("R5 short_flag vs model", short_flag, m_short);
         chk("R7 irq vs model", irq, (m_long & long_ie) | (m_short & short_ie));
      end
   end

   // Drives n cycles of one source's tick (0 xtal, 1 sys, 2 pre)
   task automatic pulse(input int which, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         xtal_tick = (which == 0); sys_tick = (which == 1); pre_tick = (which == 2);
      end
      @(negedge clk);
      xtal_tick = 0; sys_tick = 0; pre_tick = 0;
   endtask

   task automatic clear_flags();
      @(negedge clk); flag_clr = 1;
      @(negedge clk); flag_clr = 0;
   endtask

   task automatic switch_src(input logic [1:0] s);
      @(negedge clk); src_sel = s;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 long in reset", long_flag, 1'b0);
      chk("R1 short in reset", short_flag, 1'b0);
      chk("R1 irq in reset", irq, 1'b0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 long after reset", long_flag, 1'b0);
      chk("R1 irq after reset", irq, 1'b0);

      // Short period 32 on system tick
      switch_src(2'd1);
      pulse(1, 31);
      chk("R5 short before 32", short_flag, 1'b0);
      pulse(1, 1);
      chk("R5 short at 32", short_flag, 1'b1);
      chk("R7 irq with short", irq, 1'b1);
      clear_flags();
      chk("R6 short cleared", short_flag, 1'b0);
      chk("R7 irq cleared", irq, 1'b0);

      // Period 128: count is 32, next carry at 128
      ivl_sel = 2'd1;
      pulse(1, 95);
      chk("R5 short before 128", short_flag, 1'b0);
      pulse(1, 1);
      chk("R5 short at 128", short_flag, 1'b1);
      @(negedge clk); short_ie = 0;
      #1 chk("R7 irq masked", irq, 1'b0);
      @(negedge clk); short_ie = 1;
      #1 chk("R7 irq unmasked", irq, 1'b1);

      // Unselected sources ignored (count 128, period 32)
      clear_flags();
      ivl_sel = 2'd0;
      pulse(0, 100);
      pulse(2, 100);
      chk("R2 foreign ticks ignored", short_flag, 1'b0);
      pulse(1, 32);
      chk("R3 count resumes at 160", short_flag, 1'b1);

      // Source change restarts the chain
      clear_flags();
      pulse(1, 16);
      @(negedge clk); src_sel = 2'd2; pre_tick = 1;
      pulse(2, 16);
      chk("R8 no stale carry after switch", short_flag, 1'b0);
      pulse(2, 16);
      chk("R8 full period after switch", short_flag, 1'b1);

      // Reserved source holds
      clear_flags();
      @(negedge clk); src_sel = 2'd3;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk); xtal_tick = 1; sys_tick = 1; pre_tick = 1;
      end
      @(negedge clk); xtal_tick = 0; sys_tick = 0; pre_tick = 0;
      chk("R2 no source holds", short_flag, 1'b0);

      // Long period on crystal tick
      ivl_sel = 2'd3;
      @(negedge clk); src_sel = 2'd0; flag_clr = 1;
      @(negedge clk); flag_clr = 0;
      pulse(0, 16383);
      chk("R4 long before 16384", long_flag, 1'b0);
      chk("R5 short at 2048 multiples", short_flag, 1'b1);
      pulse(0, 1);
      chk("R4 long at 16384", long_flag, 1'b1);
      repeat (10) @(negedge clk);
      chk("R6 long sticky", long_flag, 1'b1);
      clear_flags();
      chk("R6 long cleared", long_flag, 1'b0);
      pulse(0, 2047);
      chk("R3 wrapped count below 2048", short_flag, 1'b0);
      @(negedge clk); xtal_tick = 1; flag_clr = 1;
      @(negedge clk); xtal_tick = 0; flag_clr = 0;
      chk("R6 set wins over clear", short_flag, 1'b1);
      chk("R6 clear still empties long", long_flag, 1'b0);

      repeat (4) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule